// File: doc/BRIEF.md
# Selectable-Coverage Odd Parity Checker

This block checks odd parity on each transmit character as it is captured. A character has eight data bits, two control bits and one separate parity bit. A two-bit coverage select and an encoder-enable flag decide which bits are checked together with the parity bit. The coverage is none, the eight data bits only, or all ten bits.

A character-valid strobe qualifies each character. When a checked character fails, the block raises a one-cycle error pulse in the next clock cycle. A sticky flag also records every failure and holds it until a synchronous clear is applied. The block sits beside the transmit input register. It takes the registered character and reports parity faults. It does not change the data.

Top module: `odd_par_chk`

## Requirements
- R1: Parity is odd. The covered bits plus the parity bit must hold an odd number of ones. An even count is an error.
- R2: With coverage select 2'b00 (off), no error pulse is ever raised. This holds whatever the character, the parity bit or the encoder flag.
- R3: Coverage select 2'b11 behaves exactly like 2'b00, so checking is off.
- R4: With coverage select 2'b01 and the encoder enabled, only data bits [7:0] and the parity bit are checked. The control bits have no effect.
- R5: With coverage select 2'b10 and the encoder enabled, data bits [7:0], control bits [1:0] and the parity bit are checked.
- R6: With the encoder bypassed, coverage selects 2'b01 and 2'b10 both check all ten bits plus the parity bit.
- R7: The error pulse is registered. It is high for exactly one cycle, in the cycle after a valid character fails. No pulse is raised when the valid strobe is low.
- R8: The sticky flag sets in the same cycle as the error pulse. It stays set until a synchronous clear. When a clear and a new failure fall in the same cycle, the failure wins and the flag stays set.
- R9: After reset, the error pulse and the sticky flag are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chr_vld | input | 1 | Character-valid strobe |
| chr_data | input | 8 | Data bits of the character |
| chr_ctl | input | 2 | Control bits of the character |
| chr_par | input | 1 | Odd parity bit |
| cov_sel | input | 2 | Coverage select: 00 off, 01 mid, 10 high, 11 off |
| enc_en | input | 1 | 1 = encoder enabled, 0 = bypassed |
| sticky_clr | input | 1 | Synchronous clear of the sticky flag |
| par_err | output | 1 | One-cycle parity error pulse |
| par_err_sticky | output | 1 | Latched parity error flag |

## Verification
The sticky clear and a fresh parity failure can fall in the same cycle. The bench provokes this by driving a failing valid character together with the clear, while the flag is already set. It then checks that both the pulse and the flag are high one cycle later. It also applies the clear alone and checks that the flag drops, and applies the clear with a passing character and checks that the flag stays low.

// File: rtl/odd_par_pkg.sv
package odd_par_pkg;
    parameter int DATA_W = 8;
    parameter int CTL_W  = 2;

    typedef enum logic [1:0] {
        COV_OFF  = 2'b00,
        COV_MID  = 2'b01,
        COV_HIGH = 2'b10,
        COV_OFF2 = 2'b11
    } cov_e;

    typedef enum logic [1:0] {
        SPAN_NONE = 2'b00,
        SPAN_DATA = 2'b01,
        SPAN_FULL = 2'b10
    } span_e;

    typedef struct packed {
        logic err;
        logic sticky;
    } st_t;
endpackage

// File: rtl/odd_par_span.sv
module odd_par_span
    import odd_par_pkg::*;
(
    input  logic [1:0] cov_sel,
    input  logic       enc_en,
    output span_e      span
);
    always_comb begin
        unique case (cov_e'(cov_sel))
            COV_MID:  span = enc_en ? SPAN_DATA : SPAN_FULL;
            COV_HIGH: span = SPAN_FULL;
            default:  span = SPAN_NONE;
        endcase
    end
endmodule

// File: rtl/odd_par_calc.sv
module odd_par_calc
    import odd_par_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = CTL_W
) (
    input  logic [DW-1:0] data,
    input  logic [CW-1:0] ctl,
    input  logic          par,
    input  span_e         span,
    output logic          bad
);
    localparam int TW = DW + CW;
    logic [TW-1:0] word;
    logic [TW-1:0] acc;
    logic data_x, full_x;

    assign word = {ctl, data};

    genvar i;
    generate
        for (i = 0; i < TW; i++) begin : g_chain
            if (i == 0) begin : g_first
                assign acc[i] = word[i];
            end else begin : g_rest
                assign acc[i] = acc[i-1] ^ word[i];
            end
        end
    endgenerate

    assign data_x = acc[DW-1] ^ par;
    assign full_x = acc[TW-1] ^ par;

    always_comb begin
        unique case (span)
            SPAN_DATA: bad = ~data_x;
            SPAN_FULL: bad = ~full_x;
            default:   bad = 1'b0;
        endcase
    end
endmodule

// File: rtl/odd_par_chk.sv
module odd_par_chk
    import odd_par_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = CTL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chr_vld,
    input  logic [DW-1:0] chr_data,
    input  logic [CW-1:0] chr_ctl,
    input  logic          chr_par,
    input  logic [1:0]    cov_sel,
    input  logic          enc_en,
    input  logic          sticky_clr,
    output logic          par_err,
    output logic          par_err_sticky
);
    span_e span;
    logic  bad;
    st_t   st_d, st_q;

    odd_par_span u_span (
        .cov_sel (cov_sel),
        .enc_en  (enc_en),
        .span    (span)
    );

    odd_par_calc #(.DW(DW), .CW(CW)) u_calc (
        .data (chr_data),
        .ctl  (chr_ctl),
        .par  (chr_par),
        .span (span),
        .bad  (bad)
    );

    always_comb begin
        st_d        = st_q;
        st_d.err    = chr_vld & bad;
        if (sticky_clr)
            st_d.sticky = 1'b0;
        if (st_d.err)
            st_d.sticky = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign par_err        = st_q.err;
    assign par_err_sticky = st_q.sticky;

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cov_sel == 2'b00) |=> !par_err);  // R2
    AST_OFF11_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cov_sel == 2'b11) |=> !par_err);  // R3
    AST_NOVLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !chr_vld |=> !par_err);  // R7
    AST_ERR_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        par_err |-> par_err_sticky);  // R8
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (par_err_sticky && !sticky_clr) |=> par_err_sticky);  // R8
    AST_MID_ENC: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_vld && cov_sel == 2'b01 && enc_en) |=>
        (par_err == ~(^{$past(chr_data), $past(chr_par)})));  // R4
    AST_FULL_CHK: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_vld && cov_sel == 2'b10) |=>
        (par_err == ~(^{$past(chr_ctl), $past(chr_data), $past(chr_par)})));  // R5
endmodule

// File: tb/tb_odd_par_chk.sv
module tb_odd_par_chk;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       chr_vld = 1'b0;
    logic [7:0] chr_data = '0;
    logic [1:0] chr_ctl = '0;
    logic       chr_par = 1'b0;
    logic [1:0] cov_sel = '0;
    logic       enc_en = 1'b1;
    logic       sticky_clr = 1'b0;
    logic       par_err, par_err_sticky;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    odd_par_chk dut (
        .clk(clk), .rst_n(rst_n), .chr_vld(chr_vld), .chr_data(chr_data),
        .chr_ctl(chr_ctl), .chr_par(chr_par), .cov_sel(cov_sel),
        .enc_en(enc_en), .sticky_clr(sticky_clr),
        .par_err(par_err), .par_err_sticky(par_err_sticky)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%b exp=%b", req, act, exp);
        end
    endtask

    function automatic logic model(input logic [7:0] d, input logic [1:0] c,
                                   input logic p, input logic [1:0] s, input logic e);
        int n;
        n = $countones(d) + (p ? 1 : 0);
        if (s == 2'b00 || s == 2'b11) return 1'b0;
        if (s == 2'b10 || !e) n += $countones(c);
        return (n % 2) == 0;
    endfunction

    task automatic send(input logic [7:0] d, input logic [1:0] c, input logic p,
                        input logic [1:0] s, input logic e, input logic clr);
        @(negedge clk);
        chr_vld = 1'b1; chr_data = d; chr_ctl = c; chr_par = p;
        cov_sel = s; enc_en = e; sticky_clr = clr;
        @(negedge clk);
        chr_vld = 1'b0; sticky_clr = 1'b0;
    endtask

    task automatic clear_sticky();
        @(negedge clk); sticky_clr = 1'b1;
        @(negedge clk); sticky_clr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R9 err", par_err, 1'b0);
        chk("R9 sticky", par_err_sticky, 1'b0);
    endtask

    task automatic t_off();
        for (int k = 0; k < 8; k++) begin
            logic [1:0] s;
            s = (k < 4) ? 2'b00 : 2'b11;
            send(8'(k * 37), 2'(k), k[0], s, k[1], 1'b0);
            chk(s == 2'b00 ? "R2 off" : "R3 code11", par_err, 1'b0);
        end
        chk("R2 sticky", par_err_sticky, 1'b0);
    endtask

    task automatic t_mid_enc();
        // 8'h01 has one 1, par 0 -> odd -> ok regardless of ctl (R4)
        send(8'h01, 2'b01, 1'b0, 2'b01, 1'b1, 1'b0);
        chk("R4 ctl ignored", par_err, 1'b0);
        send(8'h03, 2'b01, 1'b0, 2'b01, 1'b1, 1'b0);
        chk("R4 even fails", par_err, 1'b1);
        chk("R1 odd rule", par_err, model(8'h03, 2'b01, 1'b0, 2'b01, 1'b1));
        clear_sticky();
    endtask

    task automatic t_high_enc();
        send(8'h01, 2'b01, 1'b0, 2'b10, 1'b1, 1'b0);
        chk("R5 ctl counted", par_err, 1'b1);
        send(8'h01, 2'b11, 1'b0, 2'b10, 1'b1, 1'b0);
        chk("R5 ok", par_err, 1'b0);
        clear_sticky();
    endtask

    task automatic t_bypass();
        send(8'h01, 2'b01, 1'b0, 2'b01, 1'b0, 1'b0);
        chk("R6 mid bypass full", par_err, 1'b1);
        send(8'h00, 2'b01, 1'b0, 2'b10, 1'b0, 1'b0);
        chk("R6 high bypass ok", par_err, 1'b0);
        for (int k = 0; k < 16; k++) begin
            logic [7:0] d; logic [1:0] c; logic p, e; logic [1:0] s;
            d = 8'(k * 91 + 5); c = 2'(k >> 2); p = k[0]; e = k[3];
            s = 2'(k % 3 + 0);
            send(d, c, p, s, e, 1'b0);
            chk("R1 sweep", par_err, model(d, c, p, s, e));
        end
        clear_sticky();
    endtask

    task automatic t_pulse_sticky();
        chk("R8 cleared", par_err_sticky, 1'b0);
        send(8'h00, 2'b00, 1'b0, 2'b10, 1'b1, 1'b0);
        chk("R7 pulse", par_err, 1'b1);
        chk("R8 set", par_err_sticky, 1'b1);
        @(negedge clk);
        chk("R7 one cycle", par_err, 1'b0);
        chk("R8 holds", par_err_sticky, 1'b1);
        // failing data with valid low: no pulse
        @(negedge clk);
        chr_data = 8'h00; chr_par = 1'b0; cov_sel = 2'b10; chr_vld = 1'b0;
        @(negedge clk);
        chk("R7 no vld", par_err, 1'b0);
        // clear collides with fresh failure
        send(8'h00, 2'b00, 1'b0, 2'b10, 1'b1, 1'b1);
        chk("R8 collide pulse", par_err, 1'b1);
        chk("R8 collide sticky", par_err_sticky, 1'b1);
        clear_sticky();
        chk("R8 clear", par_err_sticky, 1'b0);
        send(8'h01, 2'b00, 1'b0, 2'b10, 1'b1, 1'b1);
        chk("R8 clear with good", par_err_sticky, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_off();
        t_mid_enc();
        t_high_enc();
        t_bypass();
        t_pulse_sticky();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=hung exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule